// File: doc/BRIEF.md
# Legacy memory routing decoder

This block is the routing slice of a host bridge. For every CPU memory access below 4 GiB it decides whether the access is claimed by DRAM, forwarded to the PCI bus, or not claimed at all because it falls in the interrupt-controller and firmware range at the top of the space. The decision depends on where the address lands: the compatibility graphics window, the shadowed option-ROM and BIOS segments, the PCI hole between the top of low memory and the interrupt-controller base, or ordinary memory.

Software steers the legacy windows through a few bytes of a byte-addressed configuration space. Seven attribute bytes give each shadow segment separate read and write routing. A management-RAM control byte opens the graphics window to DRAM, or lets only management-mode code reach it. A read-only byte reports installed memory in 8 MiB units. Writes arrive as a dword offset with four byte enables. A lookup port takes an address, a read/write flag and the CPU's management-mode flag. One cycle later it returns the target.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset the management-RAM control byte at offset 0x72 reads 0x02, the attribute bytes at offsets 0x59 to 0x5F read 0x00, and no result is flagged valid.
- R2: A write places data byte k at offset {cfg_addr[7:2], k} when cfg_be[k] is set. Only offsets 0x59 to 0x5F and 0x72 are writable. A write to any other byte, or to a lane whose enable is clear, leaves every register unchanged. Every offset other than 0x57, 0x59 to 0x5F and 0x72 reads 0x00.
- R3: Offset 0x57 reads floor(ram_mib / 8), held at 255 when the quotient is larger. Writes do not alter it.
- R4: rt_valid is high exactly one cycle after lk_valid. rt_target then holds 2'b00 for DRAM, 2'b01 for PCI or 2'b10 for not claimed, and never 2'b11.
- R5: Shadow region 0 covers 0xF0000 to 0xFFFFF. Region j (1 to 12) covers 16 KiB starting at 0xC0000 + (j-1)*0x4000. Region j is steered by byte 0x59 + ceil(j/2): an odd j uses bits [3:0] and an even j uses bits [7:4].
- R6: In a region's nibble, bit 0 set sends reads to DRAM and bit 1 set sends writes to DRAM. A clear bit sends that access type to PCI.
- R7: An access outside management mode to 0xA0000 to 0xBFFFF goes to DRAM when bit 6 (open) of byte 0x72 is set, and to PCI otherwise.
- R8: A management-mode access to 0xA0000 to 0xBFFFF goes to DRAM when bit 6 or bit 3 (global enable) of byte 0x72 is set, and to PCI otherwise.
- R9: With tolm at or above 0x100000, an address from tolm up to 0xFEBFFFFF goes to PCI, and an address from 0x100000 up to tolm-1 goes to DRAM. An address below 0xA0000 also goes to DRAM.
- R10: Any address at or above 0xFEC00000 is reported as not claimed (2'b10).
- R11: A lookup presented in the cycle right after a configuration write is routed with the newly written attribute or control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tolm | input | 32 | Top of low memory, static |
| ram_mib | input | 16 | Installed memory in MiB, static |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Write offset; bits [1:0] ignored |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data, byte k in bits [8k+7:8k] |
| cfg_raddr | input | 8 | Read offset; bits [1:0] ignored |
| cfg_rdata | output | 32 | Combinational read data of the addressed dword |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup address |
| lk_write | input | 1 | 1 for a write access |
| lk_smm | input | 1 | 1 when the CPU is in management mode |
| rt_valid | output | 1 | Result valid, one cycle after lk_valid |
| rt_target | output | 2 | 00 DRAM, 01 PCI, 10 not claimed |

## Verification
The hardest case to reach is a lookup that depends on a register written in the previous cycle. The attribute and control state is only visible through routing results, so a stale value shows up only when the two operations are back to back. The stimulus therefore follows every attribute and control write directly with lookups into the affected window. It covers reads and writes, both management-mode values, and the first and last bytes of every 16 KiB segment. A scoreboard checks each result against a model of the registers kept in the bench.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

  typedef enum logic [1:0] {
    TGT_DRAM  = 2'b00,
    TGT_PCI   = 2'b01,
    TGT_BLOCK = 2'b10
  } tgt_e;

  localparam int unsigned SMRAM_OPEN_BIT  = 6;
  localparam int unsigned SMRAM_GEN_BIT   = 3;
  localparam int unsigned SIZE_UNIT_SHIFT = 3;   // 8 MiB units

  // Memory-size report: MiB shifted down to 8 MiB units, clamped to a byte.
  function automatic logic [7:0] size_code(input logic [15:0] mib);
    logic [15:0] units;
    units = mib >> SIZE_UNIT_SHIFT;
    if (units > 16'd255) return 8'hFF;
    return units[7:0];
  endfunction

  // Byte (relative to the first attribute byte) that steers a region.
  function automatic int unsigned attr_byte_of(input int unsigned region);
    return (region + 1) / 2;
  endfunction

  // Odd regions use the low nibble, even regions the high nibble.
  function automatic int unsigned attr_lsb_of(input int unsigned region);
    return ((region % 2) == 1) ? 0 : 4;
  endfunction

endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
  import lmr_pkg::*;
#(
  parameter int unsigned ATTR_BYTES = 7,
  parameter logic [7:0]  ATTR_OFF   = 8'h59,
  parameter logic [7:0]  SMRAM_OFF  = 8'h72,
  parameter logic [7:0]  SIZE_OFF   = 8'h57,
  parameter logic [7:0]  SMRAM_RST  = 8'h02
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             ram_mib,
  input  logic                    wr_en,
  input  logic [7:0]              wr_addr,
  input  logic [3:0]              wr_be,
  input  logic [31:0]             wr_data,
  input  logic [7:0]              rd_addr,
  output logic [31:0]             rd_data,
  output logic [ATTR_BYTES*8-1:0] attr_flat,
  output logic [7:0]              smram_q,
  output logic [ATTR_BYTES-1:0]   attr_hit,
  output logic                    smram_hit
);

  logic [7:0] size_byte;
  assign size_byte = size_code(ram_mib);

  // One register per attribute byte, each with its own lane decode.
  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    localparam logic [7:0] OFF = 8'(int'(ATTR_OFF) + b);
    logic [7:0] q;
    assign attr_hit[b] = wr_en && (wr_addr[7:2] == OFF[7:2]) && wr_be[OFF[1:0]];
    always_ff @(posedge clk) begin
      if (!rst_n)           q <= 8'h00;
      else if (attr_hit[b]) q <= wr_data[int'(OFF[1:0])*8 +: 8];
    end
    assign attr_flat[b*8 +: 8] = q;
  end

  assign smram_hit = wr_en && (wr_addr[7:2] == SMRAM_OFF[7:2]) && wr_be[SMRAM_OFF[1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)         smram_q <= SMRAM_RST;
    else if (smram_hit) smram_q <= wr_data[int'(SMRAM_OFF[1:0])*8 +: 8];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < 4; k++) begin
      if ({rd_addr[7:2], 2'(k)} == SIZE_OFF)  rd_data[k*8 +: 8] = size_byte;
      if ({rd_addr[7:2], 2'(k)} == SMRAM_OFF) rd_data[k*8 +: 8] = smram_q;
      for (int b = 0; b < ATTR_BYTES; b++) begin
        if ({rd_addr[7:2], 2'(k)} == 8'(int'(ATTR_OFF) + b))
          rd_data[k*8 +: 8] = attr_flat[b*8 +: 8];
      end
    end
  end

  logic unused_low;
  assign unused_low = ^{wr_addr[1:0], rd_addr[1:0]};

  AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|attr_hit) |=> $stable(attr_flat)); // R2
  AST_SMRAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smram_hit |=> $stable(smram_q)); // R2
  AST_SIZE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_mib >= 16'd2040) |-> (size_byte == 8'hFF)); // R3

endmodule

// File: rtl/lmr_route.sv
module lmr_route
  import lmr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_REGIONS = 13,
  parameter int unsigned ATTR_BYTES  = 7,
  parameter int unsigned SEG_SHIFT   = 14,
  parameter logic [ADDR_W-1:0] SMW_BASE    = 'h000A_0000,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 'h000C_0000,
  parameter logic [ADDR_W-1:0] BIOS_BASE   = 'h000F_0000,
  parameter logic [ADDR_W-1:0] LEGACY_TOP  = 'h0010_0000,
  parameter logic [ADDR_W-1:0] APIC_BASE   = 'hFEC0_0000,
  localparam int unsigned RIDX_W = $clog2(NUM_REGIONS)
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    is_write,
  input  logic                    in_smm,
  input  logic [ATTR_BYTES*8-1:0] attr_flat,
  input  logic [7:0]              smram_ctl,
  input  logic [ADDR_W-1:0]       tolm,
  output tgt_e                    target,
  output logic                    hit_apic,
  output logic                    hit_smram_win,
  output logic                    hit_shadow,
  output logic                    hit_hole,
  output logic [RIDX_W-1:0]       region
);

  logic [ADDR_W-1:0] seg_off;
  logic [3:0]        sel_nib;
  logic              smram_dram;
  logic              shadow_dram;

  // BIOS segment is region 0; expansion segments count up from 1.
  function automatic logic [RIDX_W-1:0] region_of(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] off);
    if (a >= BIOS_BASE) return '0;
    return RIDX_W'((off >> SEG_SHIFT) + 1);
  endfunction

  assign hit_apic      = (addr >= APIC_BASE);
  assign hit_smram_win = (addr >= SMW_BASE) && (addr < SHADOW_BASE);
  assign hit_shadow    = (addr >= SHADOW_BASE) && (addr < LEGACY_TOP);
  assign hit_hole      = !hit_apic && (addr >= LEGACY_TOP) && (addr >= tolm);
  assign seg_off       = addr - SHADOW_BASE;
  assign region        = region_of(addr, seg_off);

  always_comb begin
    sel_nib = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (region == RIDX_W'(r))
        sel_nib = attr_flat[attr_byte_of(r)*8 + attr_lsb_of(r) +: 4];
    end
  end

  assign shadow_dram = is_write ? sel_nib[1] : sel_nib[0];
  assign smram_dram  = smram_ctl[SMRAM_OPEN_BIT] || (in_smm && smram_ctl[SMRAM_GEN_BIT]);

  always_comb begin
    if (hit_apic)           target = TGT_BLOCK;
    else if (hit_smram_win) target = smram_dram  ? TGT_DRAM : TGT_PCI;
    else if (hit_shadow)    target = shadow_dram ? TGT_DRAM : TGT_PCI;
    else if (hit_hole)      target = TGT_PCI;
    else                    target = TGT_DRAM;
  end

  logic unused_route;
  assign unused_route = ^{attr_flat, seg_off, sel_nib[3:2]};

endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
  import lmr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_REGIONS = 13,
  parameter int unsigned SEG_SHIFT   = 14,
  parameter logic [7:0]  ATTR_OFF    = 8'h59,
  parameter logic [7:0]  SMRAM_OFF   = 8'h72,
  parameter logic [7:0]  SIZE_OFF    = 8'h57,
  parameter logic [7:0]  SMRAM_RST   = 8'h02,
  parameter logic [31:0] APIC_BASE   = 32'hFEC0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tolm,
  input  logic [15:0] ram_mib,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic [7:0]  cfg_raddr,
  output logic [31:0] cfg_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  input  logic        lk_write,
  input  logic        lk_smm,
  output logic        rt_valid,
  output logic [1:0]  rt_target
);

  localparam int unsigned ATTR_BYTES = NUM_REGIONS / 2 + 1;
  localparam int unsigned RIDX_W     = $clog2(NUM_REGIONS);

  logic [ATTR_BYTES*8-1:0] attr_flat;
  logic [7:0]              smram_q;
  logic [ATTR_BYTES-1:0]   attr_hit;
  logic                    smram_hit;
  tgt_e                    route_tgt;
  logic                    hit_apic, hit_smram_win, hit_shadow, hit_hole;
  logic [RIDX_W-1:0]       region;

  lmr_cfg_regs #(
    .ATTR_BYTES(ATTR_BYTES), .ATTR_OFF(ATTR_OFF), .SMRAM_OFF(SMRAM_OFF),
    .SIZE_OFF(SIZE_OFF), .SMRAM_RST(SMRAM_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .ram_mib(ram_mib),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_be(cfg_be), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(cfg_rdata),
    .attr_flat(attr_flat), .smram_q(smram_q),
    .attr_hit(attr_hit), .smram_hit(smram_hit)
  );

  lmr_route #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .ATTR_BYTES(ATTR_BYTES),
    .SEG_SHIFT(SEG_SHIFT), .APIC_BASE(APIC_BASE)
  ) u_route (
    .addr(lk_addr), .is_write(lk_write), .in_smm(lk_smm),
    .attr_flat(attr_flat), .smram_ctl(smram_q), .tolm(tolm),
    .target(route_tgt), .hit_apic(hit_apic), .hit_smram_win(hit_smram_win),
    .hit_shadow(hit_shadow), .hit_hole(hit_hole), .region(region)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_valid  <= 1'b0;
      rt_target <= TGT_DRAM;
    end else begin
      rt_valid <= lk_valid;
      if (lk_valid) rt_target <= route_tgt;
    end
  end

  logic unused_top;
  assign unused_top = ^{hit_shadow, hit_hole, region};

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rt_valid); // R4
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rt_valid); // R4
  AST_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> (rt_target != 2'b11)); // R4
  AST_APIC_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (lk_addr >= APIC_BASE)) |=> (rt_target == TGT_BLOCK)); // R10
  AST_HOLE_TO_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && (lk_addr >= tolm) && (lk_addr >= 32'h0010_0000) && (lk_addr < APIC_BASE))
      |=> (rt_target == TGT_PCI)); // R9
  AST_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_smram_win && !lk_smm && !smram_q[SMRAM_OPEN_BIT])
      |=> (rt_target == TGT_PCI)); // R7
  AST_WINDOW_SMM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_smram_win && lk_smm && smram_q[SMRAM_GEN_BIT])
      |=> (rt_target == TGT_DRAM)); // R8

endmodule

// File: tb/legacy_mem_router_tb.sv
`timescale 1ns/1ps
module legacy_mem_router_tb;

  localparam logic [1:0] E_DRAM = 2'b00, E_PCI = 2'b01, E_BLK = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tolm = 32'h0800_0000;
  logic [15:0] ram_mib = 16'd512;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_write = 1'b0;
  logic        lk_smm = 1'b0;
  logic        rt_valid;
  logic [1:0]  rt_target;

  always #2.5 clk = ~clk;

  legacy_mem_router u_dut (
    .clk(clk), .rst_n(rst_n), .tolm(tolm), .ram_mib(ram_mib),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_write(lk_write), .lk_smm(lk_smm),
    .rt_valid(rt_valid), .rt_target(rt_target)
  );

  int total = 0;
  int bad = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  // Bench-side register model.
  logic [7:0] m_attr [7];
  logic [7:0] m_smram;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_size();
    int u;
    u = int'(ram_mib) / 8;
    return (u > 255) ? 8'd255 : 8'(u);
  endfunction

  function automatic logic [31:0] m_dword(logic [7:0] a);
    logic [31:0] d;
    int off;
    d = '0;
    for (int k = 0; k < 4; k++) begin
      off = int'({a[7:2], 2'b00}) + k;
      if (off == 'h57) d[k*8 +: 8] = m_size();
      else if (off >= 'h59 && off <= 'h5F) d[k*8 +: 8] = m_attr[off - 'h59];
      else if (off == 'h72) d[k*8 +: 8] = m_smram;
    end
    return d;
  endfunction

  function automatic logic [1:0] m_route(logic [31:0] a, logic wr, logic smm);
    int rg;
    logic [7:0] byt;
    logic [3:0] nib;
    if (a >= 32'hFEC0_0000) return E_BLK;
    if (a >= 32'h000A_0000 && a < 32'h000C_0000)
      return (m_smram[6] || (smm && m_smram[3])) ? E_DRAM : E_PCI;
    if (a >= 32'h000C_0000 && a < 32'h0010_0000) begin
      rg = (a >= 32'h000F_0000) ? 0 : int'((a - 32'h000C_0000) / 32'd16384) + 1;
      byt = m_attr[(rg + 1) / 2];
      nib = (rg % 2 == 1) ? byt[3:0] : byt[7:4];
      return (wr ? nib[1] : nib[0]) ? E_DRAM : E_PCI;
    end
    if (a >= 32'h0010_0000 && a >= tolm) return E_PCI;
    return E_DRAM;
  endfunction

  task automatic cfg_wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    int off;
    @(negedge clk);
    lk_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    for (int k = 0; k < 4; k++) begin
      off = int'({a[7:2], 2'b00}) + k;
      if (be[k]) begin
        if (off >= 'h59 && off <= 'h5F) m_attr[off - 'h59] = d[k*8 +: 8];
        else if (off == 'h72) m_smram = d[k*8 +: 8];
      end
    end
  endtask

  task automatic look(logic [31:0] a, logic wr, logic smm, string req);
    @(negedge clk);
    cfg_we = 1'b0;
    lk_valid = 1'b1; lk_addr = a; lk_write = wr; lk_smm = smm;
    exp_q.push_back(m_route(a, wr, smm));
    tag_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, string req);
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0; cfg_raddr = a;
    #1;
    chk(req, cfg_rdata, m_dword(a));
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rt_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R4 unexpected result actual=%0d expected=none", rt_target);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {30'b0, rt_target}, {30'b0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
    m_smram = 8'h02;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no result after reset", {31'b0, rt_valid}, 32'd0);
    rd_chk(8'h70, "R1 smram reset");
    rd_chk(8'h58, "R1 attr reset low");
    rd_chk(8'h5C, "R1 attr reset high");
    rd_chk(8'h54, "R3 size 512MiB");

    // Default routing.
    look(32'h000F_0000, 1'b0, 1'b0, "R6 bios read closed");
    look(32'h000C_4000, 1'b1, 1'b0, "R6 shadow write closed");
    look(32'h000A_0000, 1'b0, 1'b0, "R7 window closed");
    look(32'h000A_0000, 1'b0, 1'b1, "R8 smm without enable");
    look(32'h0005_0000, 1'b0, 1'b0, "R9 low memory");
    look(32'h07FF_FFFF, 1'b1, 1'b0, "R9 below tolm");
    look(32'h0800_0000, 1'b0, 1'b0, "R9 hole start");
    look(32'hFEBF_FFFF, 1'b0, 1'b0, "R9 hole end");
    look(32'hFEC0_0000, 1'b0, 1'b0, "R10 apic base");
    look(32'hFFFF_FFF0, 1'b1, 1'b1, "R10 top");
    idle();

    // Back-to-back write then lookup.
    cfg_wr(8'h58, 4'b0010, 32'h0000_1000);
    look(32'h000F_8000, 1'b0, 1'b0, "R11 bios read after write");
    look(32'h000F_FFFF, 1'b1, 1'b0, "R6 bios write stays pci");
    idle();

    // Distinct pattern in every region.
    cfg_wr(8'h58, 4'b1110, 32'h1221_3000);
    cfg_wr(8'h5C, 4'b1111, 32'h3201_2003);
    look(32'h000C_0000, 1'b0, 1'b0, "R11 region1 after write");
    for (int j = 1; j <= 12; j++) begin
      look(32'h000C_0000 + (j - 1) * 32'h4000, 1'b0, 1'b0, "R5 region first read");
      look(32'h000C_0000 + (j - 1) * 32'h4000 + 32'h3FFF, 1'b1, 1'b0, "R5 region last write");
      look(32'h000C_0000 + (j - 1) * 32'h4000 + 32'h2000, 1'b1, 1'b1, "R6 region mid write");
    end
    look(32'h000F_0000, 1'b1, 1'b0, "R5 bios uses high nibble");
    idle();
    rd_chk(8'h58, "R2 attr readback");
    rd_chk(8'h5C, "R2 attr readback high");

    // Ignored writes.
    cfg_wr(8'h54, 4'b1111, 32'hFFFF_FFFF);
    cfg_wr(8'h70, 4'b1011, 32'hFFFF_FFFF);
    cfg_wr(8'h5C, 4'b0000, 32'hFFFF_FFFF);
    rd_chk(8'h54, "R3 size read-only");
    rd_chk(8'h70, "R2 masked lane keeps smram");
    rd_chk(8'h5C, "R2 no enable no change");
    rd_chk(8'h60, "R2 unused offset reads zero");
    look(32'h000A_0000, 1'b0, 1'b1, "R2 window unchanged");
    idle();

    // Management-RAM control.
    cfg_wr(8'h70, 4'b0100, 32'h0008_0000);
    look(32'h000A_0000, 1'b0, 1'b1, "R11 smm enable after write");
    look(32'h000B_FFFF, 1'b1, 1'b1, "R8 smm write enable");
    look(32'h000A_0000, 1'b0, 1'b0, "R7 enable only non-smm pci");
    cfg_wr(8'h70, 4'b0100, 32'h0040_0000);
    look(32'h000B_0000, 1'b1, 1'b0, "R7 open non-smm dram");
    look(32'h000B_0000, 1'b0, 1'b1, "R8 open smm dram");
    cfg_wr(8'h70, 4'b0100, 32'h0000_0000);
    look(32'h000A_8000, 1'b0, 1'b0, "R7 closed again");
    look(32'h000A_8000, 1'b0, 1'b1, "R8 closed again");
    idle();

    // Memory-size clamp.
    ram_mib = 16'd4096;  rd_chk(8'h54, "R3 4096MiB");
    ram_mib = 16'd2047;  rd_chk(8'h54, "R3 2047MiB");
    ram_mib = 16'd2039;  rd_chk(8'h54, "R3 2039MiB");
    ram_mib = 16'd15;    rd_chk(8'h54, "R3 15MiB");

    // Different top of low memory.
    @(negedge clk);
    tolm = 32'h4000_0000;
    look(32'h3FFF_FFFF, 1'b0, 1'b0, "R9 just below new tolm");
    look(32'h4000_0000, 1'b1, 1'b0, "R9 new tolm");
    look(32'h0009_FFFF, 1'b0, 1'b1, "R9 below window");
    idle();
    idle();
    idle();
    chk("R4 all results returned", exp_q.size(), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule